// File: doc/BRIEF.md
# GPIO Port Register Slice with Masked-Write Aliases

This block holds the control state for one port of eight general-purpose pins and exposes it on a simple single-cycle register bus. Each pin has three control bits. The first is a mode bit that hands the pad to the GPIO function. The second is a drive-enable bit. The third is an output level. The block also has a read-only view of the pin levels, taken after a two-flop synchronizer.

Each control register can be written in two ways. A direct write replaces all eight bits. A write to the register's alias window changes only the bits that software selects, so there is no read-modify-write and no lock between agents that share the port. In a masked write, the upper half of the low sixteen data bits chooses which pins change, and the lower half gives their new levels.

Four such ports share a bank. The instance's position is set by two parameters, a bank index and a port index. The bank base steps by a parameterised bank stride, and the port adds one word to it. Addresses are byte addresses of 32-bit words. Bits 1:0 of the address are ignored.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, the mode, drive-enable and output-level registers are all 0, pad_out, pad_oe and gpio_en are 0, and rsp_valid is 0.
- R2: With base = BANK_IDX*BANK_STRIDE + PORT_IDX*4, the direct registers are at base+0x00 (mode), base+0x10 (drive enable), base+0x20 (output level) and base+0x30 (pin input). The three control registers also answer at base+ALIAS_OFS plus the same offset. A write to one register leaves the other two unchanged.
- R3: A direct write loads wdata[7:0] into the addressed control register. Data bits 31:8 have no effect.
- R4: A write to an alias address updates pin n only when wdata[8+n] is 1, and then loads wdata[n]. Pins whose select bit is 0 keep their value. Data bits 31:16 have no effect.
- R5: A read of a control register through either its direct or its alias address returns the current value in rdata[7:0], with rdata[31:8] = 0.
- R6: Writes to the pin-input address, and to the alias-window offset 0x30 (which is not mapped), change no register.
- R7: The pin-input register presents pin_in delayed by two clock edges. A read sampled at the edge where a new level first reaches the second synchronizer flop still returns the older level.
- R8: gpio_en equals the mode register, pad_out equals the output-level register, and pad_oe is 1 for a pin only when both its mode bit and its drive-enable bit are 1.
- R9: An address that matches no register (another port, another bank, or an unused offset) reads as 0, and a write to it changes nothing.
- R10: rsp_valid is 1 exactly one cycle after each accepted read request. It is 0 after a write and after an idle cycle. rsp_rdata is valid while rsp_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (12) | Byte address |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after a read) |
| rsp_rdata | output | DATA_W (32) | Read data |
| pin_in | input | NPINS (8) | Asynchronous pin levels |
| pad_out | output | NPINS (8) | Output levels toward the pads |
| pad_oe | output | NPINS (8) | Per-pin drive enable (mode and drive enable both set) |
| gpio_en | output | NPINS (8) | Per-pin GPIO mode select toward the pad mux |

## Verification
Two functions can act in the same cycle. One is a bus read of the pin-input register. The other is the synchronizer's second stage taking in a new level. The bench provokes this by looping pad_out back onto pin_in, changing the output level with a masked write, and then issuing reads back to back. The reads sampled at the first and second edges after the write must return the old level, and the third must return the new one. The same loopback shows that a single write is seen at the pads at once and through the synchronizer two edges later.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Widest port the merge helper supports; a masked write needs 2*NPINS data bits.
  localparam int PIN_MAX = 16;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_MODE = 3'd1,
    SEL_DRV  = 3'd2,
    SEL_LVL  = 3'd3,
    SEL_PIN  = 3'd4
  } reg_sel_e;

  // Register kind k (0..3) maps to its select code.
  function automatic reg_sel_e sel_of_idx(input int k);
    case (k)
      0:       return SEL_MODE;
      1:       return SEL_DRV;
      2:       return SEL_LVL;
      3:       return SEL_PIN;
      default: return SEL_NONE;
    endcase
  endfunction

  // Byte offset of register kind k inside a port window.
  function automatic int kind_offset(input int k);
    return 16 * k;
  endfunction

  // Bit-select merge: a set bit in sel takes the new value, a clear one keeps cur.
  function automatic logic [PIN_MAX-1:0] merge_masked(
    input logic [PIN_MAX-1:0] cur,
    input logic [PIN_MAX-1:0] nval,
    input logic [PIN_MAX-1:0] sel
  );
    return (cur & ~sel) | (nval & sel);
  endfunction

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BANK_IDX    = 1,
  parameter int PORT_IDX    = 2,
  parameter int BANK_STRIDE = 256,
  parameter int ALIAS_OFS   = 128
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              alias_hit
);

  localparam int WA        = ADDR_W - 2;
  localparam int NKIND     = 4;
  localparam int PORT_BASE = BANK_IDX * BANK_STRIDE + PORT_IDX * 4;

  logic [WA-1:0]    word_addr;
  logic [NKIND-1:0] hit_direct;
  logic [NKIND-1:0] hit_alias;

  assign word_addr = addr[ADDR_W-1:2];

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    localparam logic [WA-1:0] DIR_W = WA'((PORT_BASE + kind_offset(k)) / 4);
    localparam logic [WA-1:0] ALI_W = WA'((PORT_BASE + ALIAS_OFS + kind_offset(k)) / 4);
    assign hit_direct[k] = (word_addr == DIR_W);
    if (k < NKIND - 1) begin : g_has_alias
      assign hit_alias[k] = (word_addr == ALI_W);
    end else begin : g_no_alias
      assign hit_alias[k] = 1'b0;
    end
  end

  always_comb begin
    sel       = SEL_NONE;
    alias_hit = 1'b0;
    for (int k = 0; k < NKIND; k++) begin
      if (hit_direct[k]) begin
        sel       = sel_of_idx(k);
        alias_hit = 1'b0;
      end
      if (hit_alias[k]) begin
        sel       = sel_of_idx(k);
        alias_hit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/gpio_port_ctrl_reg.sv
module gpio_port_ctrl_reg
  import gpio_port_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_direct,
  input  logic              wr_masked,
  input  logic [DATA_W-1:0] wdata,
  output logic [NPINS-1:0]  q
);

  logic [NPINS-1:0] wr_val;
  logic [NPINS-1:0] wr_sel;
  logic [NPINS-1:0] q_next;

  assign wr_val = wdata[NPINS-1:0];
  assign wr_sel = wdata[2*NPINS-1:NPINS];

  always_comb begin
    q_next = q;
    if (wr_direct) begin
      q_next = wr_val;
    end else if (wr_masked) begin
      q_next = NPINS'(merge_masked(PIN_MAX'(q), PIN_MAX'(wr_val), PIN_MAX'(wr_sel)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  assert_masked_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_masked |=> (((q ^ $past(q)) & ~$past(wr_sel)) == '0));

  assert_masked_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_masked |=> (((q ^ $past(wr_val)) & $past(wr_sel)) == '0));

  assert_direct_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_direct |=> (q == $past(wr_val)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_direct || wr_masked) |=> $stable(q));

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int NPINS  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_sync
);

  logic [NPINS-1:0] stage_q [STAGES];
  logic [1:0]       warm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= pin_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];

  // Counts edges since reset so the lag check never looks before reset release.
  always_ff @(posedge clk) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  if (STAGES == 2) begin : g_lag_check
    assert_sync_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd3) |-> (pin_sync == $past(pin_in, 2)));
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int BANK_IDX    = 1,
  parameter int PORT_IDX    = 2,
  parameter int BANK_STRIDE = 256,
  parameter int ALIAS_OFS   = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  gpio_en
);

  localparam int NCTRL = 3;

  reg_sel_e         sel;
  logic             alias_hit;
  logic             rd_req;
  logic             wr_req;
  logic [NPINS-1:0] ctrl_q [NCTRL];
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] rd_mux;

  assign rd_req = req_valid && !req_write;
  assign wr_req = req_valid &&  req_write;

  gpio_port_decode #(
    .ADDR_W      (ADDR_W),
    .BANK_IDX    (BANK_IDX),
    .PORT_IDX    (PORT_IDX),
    .BANK_STRIDE (BANK_STRIDE),
    .ALIAS_OFS   (ALIAS_OFS)
  ) decode_i (
    .addr      (req_addr),
    .sel       (sel),
    .alias_hit (alias_hit)
  );

  for (genvar g = 0; g < NCTRL; g++) begin : g_ctrl
    logic hit_g;
    assign hit_g = wr_req && (sel == sel_of_idx(g));
    gpio_port_ctrl_reg #(
      .NPINS  (NPINS),
      .DATA_W (DATA_W)
    ) reg_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_direct (hit_g && !alias_hit),
      .wr_masked (hit_g &&  alias_hit),
      .wdata     (req_wdata),
      .q         (ctrl_q[g])
    );
  end

  gpio_port_sync #(
    .NPINS  (NPINS),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .pin_sync (pin_sync)
  );

  always_comb begin
    case (sel)
      SEL_MODE: rd_mux = ctrl_q[0];
      SEL_DRV:  rd_mux = ctrl_q[1];
      SEL_LVL:  rd_mux = ctrl_q[2];
      SEL_PIN:  rd_mux = pin_sync;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= DATA_W'(rd_mux);
    end
  end

  assign gpio_en = ctrl_q[0];
  assign pad_oe  = ctrl_q[0] & ctrl_q[1];
  assign pad_out = ctrl_q[2];

  assert_rd_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);

  assert_rdata_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[DATA_W-1:NPINS] == '0));

  assert_unmapped_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && sel == SEL_NONE) |=> (rsp_rdata == '0));

  assert_pin_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && (sel == SEL_PIN || sel == SEL_NONE)) |=>
      ($stable(gpio_en) && $stable(pad_oe) && $stable(pad_out)));

endmodule

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb_top;

  localparam logic [11:0] BASE  = 12'h108;  // bank 1 * 0x100 + port 2 * 4
  localparam logic [11:0] ALIAS = 12'h080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0]  pin_in;
  logic [7:0]  pin_drive = '0;
  logic        loop_en = 1'b0;
  logic [7:0]  pad_out, pad_oe, gpio_en;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [3];

  always #2.5 clk = ~clk;

  assign pin_in = loop_en ? pad_out : pin_drive;

  gpio_port_regs dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
    .pin_in (pin_in), .pad_out (pad_out), .pad_oe (pad_oe), .gpio_en (gpio_en)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk); @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    req_valid = 1'b0;
  endtask

  function automatic logic [11:0] reg_addr(input int k, input bit ali);
    return BASE + 12'(16 * k) + (ali ? ALIAS : 12'h000);
  endfunction

  task automatic check_pads(input string tag);
    chk(tag, {24'h0, gpio_en}, {24'h0, mdl[0]});
    chk(tag, {24'h0, pad_oe},  {24'h0, mdl[0] & mdl[1]});
    chk(tag, {24'h0, pad_out}, {24'h0, mdl[2]});
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] d; logic v;
    for (int k = 0; k < 3; k++) begin
      bus_rd(reg_addr(k, 1'b0), d, v);
      chk(tag, d, {24'h0, mdl[k]});
    end
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired got 0 exp 1");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic v;
    for (int k = 0; k < 3; k++) mdl[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check_pads("R1 pads");
    check_regs("R1 regs");

    // R10 read response timing, write gives no response
    bus_rd(reg_addr(0, 1'b0), d, v);
    chk("R10 read valid", {31'h0, v}, 32'h1);
    bus_wr(reg_addr(2, 1'b0), 32'h0);
    chk("R10 write no rsp", {31'h0, rsp_valid}, 32'h0);
    @(negedge clk);
    chk("R10 idle no rsp", {31'h0, rsp_valid}, 32'h0);

    // R2 each direct address reaches only its own register
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < 3; j++) mdl[j] = 8'h00;
      for (int j = 0; j < 3; j++) bus_wr(reg_addr(j, 1'b0), 32'h0);
      bus_wr(reg_addr(k, 1'b0), 32'h0000_00FF);
      mdl[k] = 8'hFF;
      check_regs("R2 isolation");
      for (int j = 0; j < 3; j++) begin
        bus_rd(reg_addr(j, 1'b1), d, v);
        chk("R2 alias read", d, {24'h0, mdl[j]});
      end
    end
    for (int j = 0; j < 3; j++) begin bus_wr(reg_addr(j, 1'b0), 32'h0); mdl[j] = 8'h00; end

    // R3 direct write sweep with junk in bits 31:8, read back via alias (R5)
    for (int val = 0; val < 256; val++) begin
      bus_wr(reg_addr(0, 1'b0), {24'hA5C3F0 ^ 24'(val * 7), 8'(val)});
      mdl[0] = 8'(val);
      bus_rd(reg_addr(0, 1'b1), d, v);
      chk("R3 direct write", d, {24'h0, mdl[0]});
    end
    bus_wr(reg_addr(0, 1'b0), 32'h0); mdl[0] = 8'h00;

    // R4 masked write sweep over every select pattern for every control register
    for (int g = 0; g < 3; g++) begin
      for (int m = 0; m < 256; m++) begin
        logic [7:0] nv;
        logic [7:0] sl;
        nv = 8'((m * 53 + 17 + g * 29) % 256);
        sl = 8'(m);
        bus_wr(reg_addr(g, 1'b1), {16'hC3A5 ^ 16'(m), sl, nv});
        mdl[g] = (mdl[g] & ~sl) | (nv & sl);
        check_pads("R8 pads after masked write");
        bus_rd(reg_addr(g, (m % 2) == 1), d, v);
        chk("R4 masked write", d, {24'h0, mdl[g]});
        chk("R5 read valid", {31'h0, v}, 32'h1);
      end
    end
    check_regs("R4 others untouched");

    // R6 writes to pin-input address and unmapped alias offset 0x30 change nothing
    pin_drive = 8'h3C;
    repeat (3) @(negedge clk);
    bus_wr(reg_addr(3, 1'b0), 32'hFFFF_FFFF);
    bus_wr(reg_addr(3, 1'b1), 32'hFFFF_FFFF);
    check_regs("R6 ctrl unchanged");
    bus_rd(reg_addr(3, 1'b0), d, v);
    chk("R6 pin read", d, 32'h0000_003C);
    bus_rd(reg_addr(3, 1'b1), d, v);
    chk("R6 unmapped alias read", d, 32'h0);

    // R9 other port, other bank, unused offset
    bus_wr(12'h10C, 32'hFFFF_FFFF);
    bus_wr(12'h008, 32'hFFFF_FFFF);
    bus_wr(12'h148, 32'hFFFF_FFFF);
    bus_wr(12'h18C, 32'hFFFF_FFFF);
    check_regs("R9 ctrl unchanged");
    check_pads("R9 pads unchanged");
    bus_rd(12'h10C, d, v);
    chk("R9 other port read", d, 32'h0);
    chk("R9 read valid", {31'h0, v}, 32'h1);
    bus_rd(12'h148, d, v);
    chk("R9 unused offset read", d, 32'h0);

    // R7 pin sweep, two-edge synchronizer
    for (int p = 0; p < 256; p++) begin
      pin_drive = 8'(p);
      @(negedge clk); @(negedge clk);
      bus_rd(reg_addr(3, 1'b0), d, v);
      chk("R7 pin sweep", d, {24'h0, 8'(p)});
    end

    // R7 exact latency: change pins, then three back-to-back reads
    pin_drive = 8'h00;
    repeat (3) @(negedge clk);
    pin_drive = 8'h96;
    bus_rd(reg_addr(3, 1'b0), d, v); chk("R7 latency edge1", d, 32'h0);
    bus_rd(reg_addr(3, 1'b0), d, v); chk("R7 latency edge2", d, 32'h0);
    bus_rd(reg_addr(3, 1'b0), d, v); chk("R7 latency edge3", d, 32'h96);

    // R7/R8 loopback: masked write to output level versus synchronizer capture
    bus_wr(reg_addr(2, 1'b0), 32'h0); mdl[2] = 8'h00;
    loop_en = 1'b1;
    repeat (3) @(negedge clk);
    bus_wr(reg_addr(2, 1'b1), 32'h0000_5A5A);
    mdl[2] = 8'h5A;
    chk("R8 loopback pad_out", {24'h0, pad_out}, 32'h5A);
    bus_rd(reg_addr(3, 1'b0), d, v); chk("R7 loopback edge1", d, 32'h0);
    bus_rd(reg_addr(3, 1'b0), d, v); chk("R7 loopback edge2", d, 32'h0);
    bus_rd(reg_addr(3, 1'b0), d, v); chk("R7 loopback edge3", d, 32'h5A);
    loop_en = 1'b0;

    report();
    $finish;
  end

endmodule